// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block keeps the pending-event flags and the per-source enable bits for one 8-bit timer. The timer has three event sources: counter overflow, compare match A and compare match B. A timer core outside this block sends a single-cycle pulse per event. Each pulse sets a sticky flag. Software reads both registers over a byte-wide register bus and clears flags by writing ones. The CPU's entry into a source's handler vector also clears that source's flag, through a per-source acknowledge input.

A source raises its interrupt request only when three things are all set: its flag, its enable bit and the global interrupt enable. The register bus is a simple control port with no handshake. A write takes effect on the clock edge where the write strobe is high. Read data is combinational from the address, so the bus never applies back-pressure.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, both the flag register and the enable register read 0x00 and all interrupt requests are low.
- R2: A pulse on `evt[i]` sets flag bit i on the next clock edge, and the flag stays set until it is cleared. Bit 0 is overflow, bit 1 is compare match A and bit 2 is compare match B. The same bit order holds in both registers and in the `evt`, `vec_ack` and `irq` vectors.
- R3: A write to the flag address (0x8) clears every flag whose data bit is one. Flags whose data bit is zero keep their value.
- R4: A high `vec_ack[i]` clears flag bit i on the next clock edge.
- R5: If an event pulse arrives in the same cycle as a write-one-clear or an acknowledge for the same flag, the flag ends up set.
- R6: The enable register at address 0x9 stores bits 2..0 as written. Bits 7..3 of both registers always read zero, and writes to those bits are ignored.
- R7: `irq[i]` equals flag i AND enable i AND `glb_ie`, as a combinational function of the registers. A request therefore falls in the cycle after its flag is cleared.
- R8: A read of any address other than 0x8 and 0x9 returns 0x00. A write to such an address changes neither register.
- R9: Clearing an enable bit masks its request but leaves the flag set. Setting the enable bit again raises the request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| evt | input | 3 | Event pulses: overflow, compare A, compare B |
| vec_ack | input | 3 | Handler-vector acknowledge per source |
| glb_ie | input | 1 | Global interrupt enable |
| irq | output | 3 | Interrupt request per source |

## Verification
The assertions watch every cycle. They check that an event always leaves its flag set, and that an acknowledge or a write-one-clear without a competing event always leaves the flag clear. They check that a request never appears without the global enable or its own enable bit, that the enable register changes only on a write to its address, and that reserved read bits stay zero. The bench's sweeps cover the rest. These are the exact read values for every flag, enable and global-enable combination, every write-one-clear and acknowledge pattern over every flag pattern, the same-cycle collisions, unmapped addresses, and flags surviving while masked.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int SRC_OVF  = 0;
  localparam int SRC_CMPA = 1;
  localparam int SRC_CMPB = 2;
  localparam int NUM_SRC  = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/tmr_irq_decode.sv
module tmr_irq_decode
  import tmr_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h8,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output reg_sel_e          sel,
  output logic              flag_wr,
  output logic              mask_wr
);
  always_comb begin
    if (addr == FLAG_ADDR)      sel = SEL_FLAG;
    else if (addr == MASK_ADDR) sel = SEL_MASK;
    else                        sel = SEL_NONE;
  end

  assign flag_wr = we && (sel == SEL_FLAG);
  assign mask_wr = we && (sel == SEL_MASK);
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  // a set in the same cycle as a clear keeps the flag, so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NSRC   = NUM_SRC,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h8,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   evt,
  input  logic [NSRC-1:0]   vec_ack,
  input  logic              glb_ie,
  output logic [NSRC-1:0]   irq
);
  localparam int RSV_W = DATA_W - NSRC;

  reg_sel_e          sel;
  logic              flag_wr;
  logic              mask_wr;
  logic [NSRC-1:0]   flag_q;
  logic [NSRC-1:0]   mask_q;
  logic [NSRC-1:0]   w1c;
  logic [RSV_W-1:0]  unused_hi;

  tmr_irq_decode #(
    .ADDR_W   (ADDR_W),
    .FLAG_ADDR(FLAG_ADDR),
    .MASK_ADDR(MASK_ADDR)
  ) u_decode (
    .addr   (bus_addr),
    .we     (bus_we),
    .sel    (sel),
    .flag_wr(flag_wr),
    .mask_wr(mask_wr)
  );

  assign w1c       = flag_wr ? bus_wdata[NSRC-1:0] : '0;
  assign unused_hi = bus_wdata[DATA_W-1:NSRC];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    tmr_irq_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(evt[i]),
      .clr_i(w1c[i] | vec_ack[i]),
      .q    (flag_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= bus_wdata[NSRC-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_FLAG: bus_rdata[NSRC-1:0] = flag_q;
      SEL_MASK: bus_rdata[NSRC-1:0] = mask_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = flag_q & mask_q & {NSRC{glb_ie}};
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NSRC   = 3,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h8,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NSRC-1:0]   evt,
  input logic [NSRC-1:0]   vec_ack,
  input logic              glb_ie,
  input logic [NSRC-1:0]   irq,
  input logic [NSRC-1:0]   flag_q,
  input logic [NSRC-1:0]   mask_q
);
  logic wr_flag, wr_mask;
  assign wr_flag = bus_we && (bus_addr == FLAG_ADDR);
  assign wr_mask = bus_we && (bus_addr == MASK_ADDR);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flag_q & $past(evt)) == $past(evt)));

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && ((bus_wdata[NSRC-1:0] & ~evt) != '0))
      |=> ((flag_q & $past(bus_wdata[NSRC-1:0] & ~evt)) == '0));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec_ack & ~evt) != '0) |=> ((flag_q & $past(vec_ack & ~evt)) == '0));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));

  p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:NSRC] == '0);

  p_irq_needs_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> glb_ie);

  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~mask_q) == '0);

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~flag_q) == '0);
endmodule

bind tmr_irq_ctrl tmr_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC),
  .FLAG_ADDR(FLAG_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt(evt),
  .vec_ack(vec_ack), .glb_ie(glb_ie), .irq(irq),
  .flag_q(flag_q), .mask_q(mask_q)
);

// File: tb/test_tmr_irq_ctrl.sv
module test_tmr_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_FLAG = 4'h8;
  localparam logic [3:0] A_MASK = 4'h9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] evt = '0;
  logic [2:0] vec_ack = '0;
  logic       glb_ie = 1'b0;
  logic [2:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_ctrl i_tmr_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt(evt),
    .vec_ack(vec_ack), .glb_ie(glb_ie), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    cyc();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic load_flags(input logic [2:0] f);
    wr(A_FLAG, 8'hFF);
    evt = f; cyc(); evt = '0;
  endtask

  logic [7:0] d;

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    rd(A_FLAG, d); chk("R1 flag", d, 8'h00);
    rd(A_MASK, d); chk("R1 mask", d, 8'h00);
    glb_ie = 1'b1; #1 chk("R1 irq", {5'b0, irq}, 8'h00);
    rst_n = 1'b1;
    cyc();

    // R2, R7: sweep flags x masks x global enable
    for (int f = 0; f < 8; f++) begin
      for (int m = 0; m < 8; m++) begin
        for (int g = 0; g < 2; g++) begin
          load_flags(f[2:0]);
          wr(A_MASK, {5'b10101, m[2:0]});
          glb_ie = g[0];
          rd(A_FLAG, d); chk("R2 flag set", d, {5'b0, f[2:0]});
          rd(A_MASK, d); chk("R6 mask rw", d, {5'b0, m[2:0]});
          chk("R7 irq", {5'b0, irq}, g[0] ? {5'b0, f[2:0] & m[2:0]} : 8'h00);
          cyc();
          rd(A_FLAG, d); chk("R2 sticky", d, {5'b0, f[2:0]});
        end
      end
    end

    // R3: write-one-clear sweep
    glb_ie = 1'b1;
    wr(A_MASK, 8'h07);
    for (int f = 0; f < 8; f++) begin
      for (int w = 0; w < 8; w++) begin
        load_flags(f[2:0]);
        wr(A_FLAG, {5'b11111, w[2:0]});
        rd(A_FLAG, d); chk("R3 w1c", d, {5'b0, f[2:0] & ~w[2:0]});
        chk("R7 irq drops", {5'b0, irq}, {5'b0, f[2:0] & ~w[2:0]});
      end
    end

    // R4: acknowledge sweep
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a < 8; a++) begin
        load_flags(f[2:0]);
        vec_ack = a[2:0]; cyc(); vec_ack = '0;
        rd(A_FLAG, d); chk("R4 ack", d, {5'b0, f[2:0] & ~a[2:0]});
      end
    end

    // R5: set wins over clear in same cycle
    for (int e = 0; e < 8; e++) begin
      load_flags(3'b000);
      evt = e[2:0]; vec_ack = 3'b111; cyc(); evt = '0; vec_ack = '0;
      rd(A_FLAG, d); chk("R5 ack collision", d, {5'b0, e[2:0]});
      load_flags(3'b000);
      evt = e[2:0]; bus_addr = A_FLAG; bus_wdata = 8'hFF; bus_we = 1'b1;
      cyc(); evt = '0; bus_we = 1'b0;
      rd(A_FLAG, d); chk("R5 w1c collision", d, {5'b0, e[2:0]});
    end

    // R6: reserved bits
    wr(A_MASK, 8'hF8);
    rd(A_MASK, d); chk("R6 reserved mask", d, 8'h00);
    load_flags(3'b111);
    rd(A_FLAG, d); chk("R6 reserved flag", d, 8'h07);

    // R8: unmapped addresses
    wr(A_MASK, 8'h05);
    for (int a = 0; a < 16; a++) begin
      if (a == 8 || a == 9) continue;
      wr(a[3:0], 8'hFF);
      rd(a[3:0], d); chk("R8 unmapped read", d, 8'h00);
      rd(A_FLAG, d); chk("R8 flag kept", d, 8'h07);
      rd(A_MASK, d); chk("R8 mask kept", d, 8'h05);
    end

    // R9: masking does not clear flag
    load_flags(3'b111);
    wr(A_MASK, 8'h00);
    chk("R9 masked irq", {5'b0, irq}, 8'h00);
    cyc();
    rd(A_FLAG, d); chk("R9 flag kept", d, 8'h07);
    wr(A_MASK, 8'h02);
    chk("R9 re-enable irq", {5'b0, irq}, 8'h02);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule